// File: doc/BRIEF.md
# Four-Mode Byte SPI Master

This block is a full-duplex serial peripheral master that sends bytes handed over by a host, most significant bit first. For every byte it shifts out on MOSI, it captures the byte present on MISO and returns it to the host with a one-cycle valid pulse. The serial clock runs at a fixed rate. It is the system clock divided by a parameter, `CLK_DIV`, whose default of 64 gives 312.5 kHz from a 20 MHz system clock. The block generates no chip select. The host drives its select line separately through ordinary I/O.

The host picks one of four clocking modes with a two-bit code. Bit 1 of the code inverts the clock polarity and bit 0 selects the alternate phase. When the host gives no mode, the normal/normal mode applies. The mode is taken in every cycle while the block is idle, so the idle clock level follows the request. It is frozen from the first accepted byte until the block returns to idle. If the host offers a new byte in the cycle of the last clock edge, the next byte follows with no idle gap.

Top module: `sbm_spi_master`

## Requirements
- R1: While a byte is in flight, SCK changes level every `CLK_DIV/2` system cycles, so one SCK period is `CLK_DIV` cycles (64 by default).
- R2: The mode code maps as follows: 0 = normal polarity/normal phase, 1 = normal/alternate, 2 = inverted/normal, 3 = inverted/alternate. Code bit 1 is polarity and code bit 0 is phase.
- R3: When `mode_en` is low, the block uses mode code 0 whatever `mode_sel` carries.
- R4: While idle, SCK rests at the polarity of the requested mode, one cycle after the request is applied (low for codes 0 and 1, high for 2 and 3).
- R5: MOSI carries the byte MSB first. With normal phase, bit 7 is on the line before the first edge and the next bit appears at each even-numbered edge. With alternate phase, each next bit appears at each odd-numbered edge from the third on. After the byte, MOSI holds bit 0.
- R6: MISO is sampled on the odd-numbered edges (normal phase) or the even-numbered edges (alternate phase), MSB first. One cycle after the 16th edge, `rx_valid` pulses for one cycle with the assembled byte on `rx_data`.
- R7: `tx_ready` is high while idle and, while busy, only in the cycle of the 16th edge. A byte is taken in any cycle where `tx_valid` and `tx_ready` are both high.
- R8: A byte accepted in the cycle of the 16th edge starts at once: the next SCK half-period follows with no idle cycle.
- R9: Changes on `mode_en` and `mode_sel` while busy have no effect on SCK or MOSI until the block is idle again.
- R10: Each byte has exactly 16 SCK edges, and SCK ends at its idle level. `busy` falls after the last byte when no next byte is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously upstream |
| mode_en | input | 1 | High when `mode_sel` carries a mode; low selects code 0 |
| mode_sel | input | 2 | Mode code: bit 1 polarity inverted, bit 0 alternate phase |
| tx_valid | input | 1 | Host offers `tx_data` |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Block takes the offered byte this cycle |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds the byte read on MISO |
| rx_data | output | 8 | Byte captured during the last transfer |
| busy | output | 1 | A byte is being shifted |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A byte taken at a rising edge leaves `busy` high and SCK at its idle level from the next cycle. The first SCK transition comes `CLK_DIV/2` cycles after acceptance, and each later transition follows `CLK_DIV/2` cycles after the previous one. `rx_valid` is due exactly one cycle after the 16th transition, and `tx_ready` is due in the cycle of that transition. The bench keeps a behavioural cycle counter for the byte in flight and derives each of these due times from it. It drives inputs and the slave's MISO at falling edges and compares every output at every falling edge, so each result is checked in the cycle it is due and in no other.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  // Mode code: bit 1 = clock inverted, bit 0 = alternate phase
  typedef enum logic [1:0] {
    SBM_NORM_NORM = 2'd0,
    SBM_NORM_ALT  = 2'd1,
    SBM_INV_NORM  = 2'd2,
    SBM_INV_ALT   = 2'd3
  } sbm_mode_e;

  function automatic logic mode_pol(input sbm_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_pha(input sbm_mode_e m);
    return m[0];
  endfunction
endpackage

// File: rtl/sbm_tick_gen.sv
module sbm_tick_gen #(
  parameter int HALF = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)             cnt_d = '0;
    else if (cnt_q == TOP) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == TOP);
endmodule

// File: rtl/sbm_edge_ctl.sv
module sbm_edge_ctl #(
  parameter int BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  input  logic pha,
  output logic sck_raw,
  output logic sample_en,
  output logic shift_en,
  output logic last_edge
);
  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  logic [EW-1:0] edge_q, edge_d;
  logic          sck_q, sck_d;

  assign last_edge = tick && (edge_q == LAST);
  // edge_q holds the count of edges already made; bit 0 clear means the coming edge is odd
  assign sample_en = tick && (edge_q[0] == pha);
  assign shift_en  = tick && (edge_q[0] != pha) && (edge_q != LAST) && (edge_q != '0);

  always_comb begin
    edge_d = edge_q;
    sck_d  = sck_q;
    if (tick) begin
      sck_d  = ~sck_q;
      edge_d = (edge_q == LAST) ? '0 : edge_q + 1'b1;
    end
    if (load) begin
      edge_d = '0;
      sck_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      sck_q  <= 1'b0;
    end else begin
      edge_q <= edge_d;
      sck_q  <= sck_d;
    end
  end

  assign sck_raw = sck_q;
endmodule

// File: rtl/sbm_shifter.sv
module sbm_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_data,
  input  logic            shift_en,
  input  logic            sample_en,
  input  logic            last_edge,
  input  logic            miso,
  output logic            mosi,
  output logic            rx_valid,
  output logic [BITS-1:0] rx_data
);
  logic [BITS-1:0] tx_q, tx_d;
  logic [BITS-1:0] rx_q, rx_d;
  logic [BITS-1:0] out_q, out_d;
  logic            vld_d, vld_q;

  always_comb begin
    tx_d  = tx_q;
    rx_d  = rx_q;
    out_d = out_q;
    vld_d = last_edge;
    if (sample_en) rx_d = {rx_q[BITS-2:0], miso};
    if (shift_en)  tx_d = {tx_q[BITS-2:0], 1'b0};
    if (load)      tx_d = load_data;
    if (last_edge) out_d = rx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      out_q <= out_d;
      vld_q <= vld_d;
    end
  end

  assign mosi     = tx_q[BITS-1];
  assign rx_valid = vld_q;
  assign rx_data  = out_q;
endmodule

// File: rtl/sbm_spi_master.sv
module sbm_spi_master
  import sbm_pkg::*;
#(
  parameter int CLK_DIV = 64,
  parameter int BITS    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_en,
  input  logic [1:0]      mode_sel,
  input  logic            tx_valid,
  input  logic [BITS-1:0] tx_data,
  output logic            tx_ready,
  output logic            rx_valid,
  output logic [BITS-1:0] rx_data,
  output logic            busy,
  output logic            sck,
  output logic            mosi,
  input  logic            miso
);
  localparam int HALF = CLK_DIV / 2;

  sbm_mode_e req_mode;
  logic      busy_q, busy_d;
  logic      pol_q, pol_d, pha_q, pha_d;
  logic      tick, accept, load;
  logic      sck_raw, sample_en, shift_en, last_edge;

  assign req_mode = mode_en ? sbm_mode_e'(mode_sel) : SBM_NORM_NORM;
  assign tx_ready = !busy_q || last_edge;
  assign accept   = tx_valid && tx_ready;
  assign load     = accept;

  always_comb begin
    busy_d = busy_q;
    pol_d  = pol_q;
    pha_d  = pha_q;
    if (!busy_q) begin
      pol_d = mode_pol(req_mode);
      pha_d = mode_pha(req_mode);
    end
    if (accept)         busy_d = 1'b1;
    else if (last_edge) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pol_q  <= 1'b0;
      pha_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      pol_q  <= pol_d;
      pha_q  <= pha_d;
    end
  end

  sbm_tick_gen #(.HALF(HALF)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_q),
    .tick (tick)
  );

  sbm_edge_ctl #(.BITS(BITS)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (load),
    .pha      (pha_q),
    .sck_raw  (sck_raw),
    .sample_en(sample_en),
    .shift_en (shift_en),
    .last_edge(last_edge)
  );

  sbm_shifter #(.BITS(BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_data(tx_data),
    .shift_en (shift_en),
    .sample_en(sample_en),
    .last_edge(last_edge),
    .miso     (miso),
    .mosi     (mosi),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
  );

  assign busy = busy_q;
  assign sck  = sck_raw ^ pol_q;
endmodule

// File: rtl/sbm_spi_master_chk.sv
module sbm_spi_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sck,
  input logic tick,
  input logic last_edge,
  input logic rx_valid,
  input logic pol_q,
  input logic pha_q,
  input logic tx_ready,
  input logic tx_valid
);
  // R1: SCK moves only on a half-period tick while busy
  p_sck_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sck)) |-> $past(tick));

  // R4: idle clock level equals polarity in use
  p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (sck == pol_q));

  // R9: mode held for the whole busy span
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(pol_q) && $stable(pha_q)));

  // R6: result pulse follows the final edge
  p_rx_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(last_edge));

  // R10: busy drops only together with a result
  p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rx_valid);

  // R7: no acceptance mid-byte
  p_ready_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_edge) |-> !tx_ready);

  // R8: byte offered at the last edge keeps the block busy
  p_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_edge && tx_valid) |=> busy);
endmodule

bind sbm_spi_master sbm_spi_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .sck      (sck),
  .tick     (tick),
  .last_edge(last_edge),
  .rx_valid (rx_valid),
  .pol_q    (pol_q),
  .pha_q    (pha_q),
  .tx_ready (tx_ready),
  .tx_valid (tx_valid)
);

// File: tb/sbm_spi_master_tb.sv
`timescale 1ns/1ps
module sbm_spi_master_tb;
  localparam int DIV  = 64;
  localparam int HALF = DIV / 2;
  localparam int BYTE_CYC = 16 * HALF;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_en;
  logic [1:0] mode_sel;
  logic tx_valid;
  logic [7:0] tx_data;
  logic tx_ready, rx_valid, busy, sck, mosi, miso;
  logic [7:0] rx_data;

  int vectors = 0;
  int errors  = 0;
  string cur_req = "R2";
  bit finished = 0;

  always #10 clk = ~clk;

  sbm_spi_master #(.CLK_DIV(DIV), .BITS(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .mode_sel(mode_sel),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  // Behavioural reference: cycle count within the byte in flight
  logic m_busy, m_rxv, m_pol, m_pha;
  int   m_t;
  logic [7:0] m_cur, m_sb, m_rxd;

  function automatic logic [7:0] slave_of(input logic [7:0] b);
    return {b[3:0], b[7:4]} ^ 8'h96;
  endfunction

  function automatic logic exp_ready();
    return !m_busy || (m_t == BYTE_CYC - 1);
  endfunction

  function automatic logic exp_sck();
    if (!m_busy) return m_pol;
    return m_pol ^ (((m_t / HALF) % 2) == 1);
  endfunction

  function automatic logic exp_mosi();
    int e, idx;
    if (!m_busy) return m_cur[0];
    e = m_t / HALF;
    if (!m_pha) idx = e / 2;
    else        idx = (e == 0) ? 0 : (e - 1) / 2;
    return m_cur[7 - idx];
  endfunction

  function automatic logic slave_bit();
    int k;
    if (!m_busy) return 1'b1;
    k = (m_t / HALF) / 2;
    return m_sb[7 - k];
  endfunction

  assign miso = slave_bit();

  always @(posedge clk or negedge rst_n) begin : ref_model
    logic acc;
    if (!rst_n) begin
      m_busy <= 1'b0; m_rxv <= 1'b0; m_pol <= 1'b0; m_pha <= 1'b0;
      m_t <= 0; m_cur <= '0; m_sb <= '0; m_rxd <= '0;
    end else begin
      acc = tx_valid && exp_ready();
      m_rxv <= 1'b0;
      if (!m_busy) begin
        m_pol <= mode_en & mode_sel[1];
        m_pha <= mode_en & mode_sel[0];
      end
      if (m_busy && m_t != BYTE_CYC - 1) begin
        m_t <= m_t + 1;
      end else begin
        if (m_busy) begin
          m_rxv <= 1'b1;
          m_rxd <= m_sb;
        end
        if (acc) begin
          m_busy <= 1'b1;
          m_t    <= 0;
          m_cur  <= tx_data;
          m_sb   <= slave_of(tx_data);
        end else begin
          m_busy <= 1'b0;
        end
      end
    end
  end

  task automatic check(input logic act, input logic exp, input string req, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s/%s %s: actual %0b expected %0b at %0t", req, cur_req, what, act, exp, $time);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(sck, exp_sck(), m_busy ? "R1" : "R4", "sck");
      check(mosi, exp_mosi(), "R5", "mosi");
      check(tx_ready, exp_ready(), "R7", "tx_ready");
      check(busy, m_busy, "R10", "busy");
      check(rx_valid, m_rxv, "R6", "rx_valid");
      if (m_rxv) begin
        vectors++;
        if (rx_data !== m_rxd) begin
          errors++;
          $display("FAIL R6/%s rx_data: actual %02h expected %02h", cur_req, rx_data, m_rxd);
        end
      end
    end
  end

  task automatic push(input logic [7:0] b);
    tx_data  = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_en = 1'b0; mode_sel = 2'd0; tx_valid = 1'b0; tx_data = '0;
    repeat (3) @(negedge clk);
    // reset state: idle, low clock, ready, no result
    check(sck, 1'b0, "R4", "reset sck");
    check(busy, 1'b0, "R10", "reset busy");
    check(tx_ready, 1'b1, "R7", "reset tx_ready");
    check(rx_valid, 1'b0, "R6", "reset rx_valid");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3: no mode given, code 3 on the select lines is ignored
    cur_req = "R3";
    mode_sel = 2'd3; mode_en = 1'b0;
    repeat (3) @(negedge clk);
    push(8'hA5);
    wait_idle();

    // R2: each code in turn
    cur_req = "R2";
    mode_en = 1'b1; mode_sel = 2'd1;
    repeat (3) @(negedge clk);
    push(8'h3C);
    wait_idle();
    mode_sel = 2'd2;
    repeat (3) @(negedge clk);
    push(8'h81);
    wait_idle();

    // R8 and R9: chained bytes, mode lines moved while busy
    cur_req = "R8";
    mode_sel = 2'd3;
    repeat (3) @(negedge clk);
    push(8'hF0);
    cur_req = "R9";
    mode_sel = 2'd0;
    push(8'h0F);
    mode_en = 1'b0;
    push(8'h5A);
    wait_idle();

    // R8: chained pair in the normal mode
    cur_req = "R8";
    mode_en = 1'b1; mode_sel = 2'd0;
    repeat (3) @(negedge clk);
    push(8'h01);
    push(8'hFE);
    wait_idle();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule